// File: doc/BRIEF.md
# Single-Bit Alias Address Bridge

This block sits between a 32-bit bus master and its memory. It turns a word access into one of two 32 MB alias windows into an operation on a single bit of a 1 MB target window. Accesses anywhere else are forwarded to the memory side unchanged.

The two windows pair up as follows: alias 0x22000000–0x23FFFFFF covers target bytes 0x20000000–0x200FFFFF, and alias 0x42000000–0x43FFFFFF covers target bytes 0x40000000–0x400FFFFF. Each alias word selects one bit. An alias read returns that bit in position 0 of the read data. An alias write becomes an indivisible read-modify-write of the target word. The read and write phases both use a single byte enable, and bit 0 of the write data gives the new value of the bit.

Instruction fetches are handled by window. A fetch into the first (memory) alias window is not remapped and goes out as an ordinary access. A fetch into the second (peripheral) alias window is refused with an error response.

Both sides use a request/ready handshake. A transfer completes in the cycle in which request and ready are both high, and read data is valid in that cycle. The master holds its request fields steady until it sees ready. Only one master request is in flight at a time.

Top module: `bitalias_bridge`

## Requirements
- R1: While reset is high and in the cycle after it, `m_ready` and `s_req` are 0.
- R2: A non-fetch access outside both alias windows produces exactly one slave access with the same address, direction and write data, and all four byte enables set. For a read, `m_rdata` equals the slave read data.
- R3: An alias address A in a window with target base T selects the target byte B = T + A[24:5] and bit A[4:2] of that byte. The slave address is B with bits [1:0] cleared. Data is little-endian, so the single byte enable and the byte lane are given by B[1:0]. For example, 0x23FFFFFC selects bit 7 of byte 0x200FFFFF (be 4'b1000), and 0x22000000 selects bit 0 of byte 0x20000000 (be 4'b0001).
- R4: An alias read makes exactly one slave read and no slave write. It returns 0x00000001 if the selected bit is 1, and 0x00000000 otherwise.
- R5: An alias write makes a slave read followed by a slave write to the same word with the same byte enable. After it, the selected bit is updated and every other bit of the word keeps its value.
- R6: Only bit 0 of the alias write data matters. Writing 0xFF sets the bit like 0x01, and writing 0x0E or 0xFE clears it like 0x00.
- R7: An instruction fetch (`m_fetch`=1) in the memory alias window is forwarded without remapping: one slave read at the original address, and the slave data is returned.
- R8: An instruction fetch in the peripheral alias window completes with `m_err`=1 and `m_rdata`=0, and makes no slave access.
- R9: Each master request is answered by exactly one single-cycle `m_ready` pulse. No further master request is accepted until the slave phases of the current one have ended.
- R10: `m_err` is 0 for every request other than the one described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request |
| m_we | input | 1 | Master write (0 = read) |
| m_fetch | input | 1 | Request is an instruction fetch (read) |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Request complete (one cycle) |
| m_rdata | output | 32 | Read data, valid with m_ready |
| m_err | output | 1 | Error response, valid with m_ready |
| s_req | output | 1 | Slave request |
| s_we | output | 1 | Slave write |
| s_addr | output | 32 | Slave word-aligned address |
| s_wdata | output | 32 | Slave write data |
| s_be | output | 4 | Slave byte enables |
| s_ready | input | 1 | Slave transfer complete |
| s_rdata | input | 32 | Slave read data, valid with s_ready |

## Verification
The assertions rely on two behaviours of the surrounding system. The master keeps address, direction and write data constant from raising `m_req` until it observes `m_ready`. The memory keeps `s_ready` low unless a request is pending. The bench master changes its inputs only on falling edges, and it changes them only once ready has been observed. The bench memory model raises ready only in answer to a pending request, after a random wait of zero to two cycles. Fetches are always issued as reads, as the block expects.

// File: rtl/ba_pkg.sv
package ba_pkg;

    localparam int BA_AW        = 32;
    localparam int BA_DW        = 32;
    localparam int BA_LANES     = BA_DW / 8;
    localparam int BA_LANE_W    = $clog2(BA_LANES);
    localparam int BA_BIT_W     = 3;
    localparam int BA_POS_W     = BA_LANE_W + BA_BIT_W;
    localparam int BA_ALIAS_LOG = 25;
    localparam int BA_NREG      = 2;

    typedef enum logic [1:0] {
        K_PASS  = 2'd0,
        K_BIT   = 2'd1,
        K_FAULT = 2'd2
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PASS  = 3'd1,
        ST_BRD   = 3'd2,
        ST_BWR   = 3'd3,
        ST_FAULT = 3'd4,
        ST_DONE  = 3'd5
    } ctrl_state_e;

    typedef struct packed {
        req_kind_e              kind;
        logic [BA_AW-1:0]       word_addr;
        logic [BA_LANE_W-1:0]   lane;
        logic [BA_BIT_W-1:0]    bit_idx;
    } decode_t;

    typedef struct packed {
        logic                   we;
        logic [BA_AW-1:0]       addr;
        logic [BA_DW-1:0]       wdata;
        decode_t                dec;
    } cmd_t;

    function automatic logic [BA_AW-1:0] region_alias_base(input int r);
        return (r == 0) ? 32'h2200_0000 : 32'h4200_0000;
    endfunction

    function automatic logic [BA_AW-1:0] region_target_base(input int r);
        return (r == 0) ? 32'h2000_0000 : 32'h4000_0000;
    endfunction

    function automatic logic region_fetch_faults(input int r);
        return (r != 0);
    endfunction

    function automatic logic [BA_LANES-1:0] lane_enable(input logic [BA_LANE_W-1:0] lane);
        logic [BA_LANES-1:0] be;
        be = '0;
        be[lane] = 1'b1;
        return be;
    endfunction

endpackage

// File: rtl/ba_decode.sv
module ba_decode
    import ba_pkg::*;
#(
    parameter int AW        = BA_AW,
    parameter int NREG      = BA_NREG,
    parameter int ALIAS_LOG = BA_ALIAS_LOG
) (
    input  logic [AW-1:0] addr,
    input  logic          fetch,
    output decode_t       dec
);
    localparam int OFF_LO = BA_BIT_W + 2;

    logic [NREG-1:0]   hit;
    logic [AW-1:0]     tgt_byte [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        localparam logic [AW-1:0] ABASE = region_alias_base(r);
        localparam logic [AW-1:0] TBASE = region_target_base(r);
        assign hit[r]      = (addr[AW-1:ALIAS_LOG] == ABASE[AW-1:ALIAS_LOG]);
        assign tgt_byte[r] = TBASE + AW'(addr[ALIAS_LOG-1:OFF_LO]);
    end

    always_comb begin
        dec           = '0;
        dec.kind      = K_PASS;
        dec.word_addr = addr;
        for (int r = NREG - 1; r >= 0; r--) begin
            if (hit[r]) begin
                if (fetch) begin
                    dec.kind = region_fetch_faults(r) ? K_FAULT : K_PASS;
                end else begin
                    dec.kind = K_BIT;
                end
                if (!fetch) begin
                    dec.word_addr = {tgt_byte[r][AW-1:BA_LANE_W], {BA_LANE_W{1'b0}}};
                end
                dec.lane    = tgt_byte[r][BA_LANE_W-1:0];
                dec.bit_idx = addr[OFF_LO-1:2];
            end
        end
    end

endmodule

// File: rtl/ba_bitop.sv
module ba_bitop
    import ba_pkg::*;
#(
    parameter int DW = BA_DW
) (
    input  logic [DW-1:0]        word_in,
    input  logic [BA_LANE_W-1:0] lane,
    input  logic [BA_BIT_W-1:0]  bit_idx,
    input  logic                 new_val,
    output logic                 bit_out,
    output logic [DW-1:0]        word_out
);
    logic [BA_POS_W-1:0] pos;
    logic [DW-1:0]       sel_mask;

    assign pos = {lane, bit_idx};

    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign sel_mask[i] = (pos == BA_POS_W'(i));
        assign word_out[i] = sel_mask[i] ? new_val : word_in[i];
    end

    assign bit_out = |(word_in & sel_mask);

endmodule

// File: rtl/ba_ctrl.sv
module ba_ctrl
    import ba_pkg::*;
#(
    parameter int AW    = BA_AW,
    parameter int DW    = BA_DW,
    parameter int LANES = BA_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             m_req,
    input  logic             m_we,
    input  logic [AW-1:0]    m_addr,
    input  logic [DW-1:0]    m_wdata,
    input  decode_t          dec_in,
    output logic             m_ready,
    output logic [DW-1:0]    m_rdata,
    output logic             m_err,
    output logic             s_req,
    output logic             s_we,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_wdata,
    output logic [LANES-1:0] s_be,
    input  logic             s_ready,
    input  logic [DW-1:0]    s_rdata
);
    ctrl_state_e     state;
    cmd_t            cmd;
    logic [DW-1:0]   rdata_q;
    logic [DW-1:0]   wr_word_q;
    logic            err_q;
    logic            bit_val;
    logic [DW-1:0]   merged;

    ba_bitop #(.DW(DW)) u_bitop (
        .word_in  (s_rdata),
        .lane     (cmd.dec.lane),
        .bit_idx  (cmd.dec.bit_idx),
        .new_val  (cmd.wdata[0]),
        .bit_out  (bit_val),
        .word_out (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cmd       <= '0;
            rdata_q   <= '0;
            wr_word_q <= '0;
            err_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (m_req) begin
                        cmd.we    <= m_we;
                        cmd.addr  <= m_addr;
                        cmd.wdata <= m_wdata;
                        cmd.dec   <= dec_in;
                        rdata_q   <= '0;
                        err_q     <= 1'b0;
                        unique case (dec_in.kind)
                            K_BIT:   state <= ST_BRD;
                            K_FAULT: state <= ST_FAULT;
                            default: state <= ST_PASS;
                        endcase
                    end
                end
                ST_PASS: begin
                    if (s_ready) begin
                        rdata_q <= cmd.we ? '0 : s_rdata;
                        state   <= ST_DONE;
                    end
                end
                ST_BRD: begin
                    if (s_ready) begin
                        if (cmd.we) begin
                            wr_word_q <= merged;
                            state     <= ST_BWR;
                        end else begin
                            rdata_q <= DW'(bit_val);
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_BWR: begin
                    if (s_ready) begin
                        state <= ST_DONE;
                    end
                end
                ST_FAULT: begin
                    err_q <= 1'b1;
                    state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        s_req   = 1'b0;
        s_we    = 1'b0;
        s_addr  = '0;
        s_wdata = '0;
        s_be    = '0;
        unique case (state)
            ST_PASS: begin
                s_req   = 1'b1;
                s_we    = cmd.we;
                s_addr  = cmd.addr;
                s_wdata = cmd.wdata;
                s_be    = '1;
            end
            ST_BRD: begin
                s_req  = 1'b1;
                s_addr = cmd.dec.word_addr;
                s_be   = lane_enable(cmd.dec.lane);
            end
            ST_BWR: begin
                s_req   = 1'b1;
                s_we    = 1'b1;
                s_addr  = cmd.dec.word_addr;
                s_wdata = wr_word_q;
                s_be    = lane_enable(cmd.dec.lane);
            end
            default: ;
        endcase
    end

    assign m_ready = (state == ST_DONE);
    assign m_rdata = m_ready ? rdata_q : '0;
    assign m_err   = m_ready & err_q;

endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
    import ba_pkg::*;
#(
    parameter int AW    = BA_AW,
    parameter int DW    = BA_DW,
    parameter int LANES = DW / 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             m_req,
    input  logic             m_we,
    input  logic             m_fetch,
    input  logic [AW-1:0]    m_addr,
    input  logic [DW-1:0]    m_wdata,
    output logic             m_ready,
    output logic [DW-1:0]    m_rdata,
    output logic             m_err,
    output logic             s_req,
    output logic             s_we,
    output logic [AW-1:0]    s_addr,
    output logic [DW-1:0]    s_wdata,
    output logic [LANES-1:0] s_be,
    input  logic             s_ready,
    input  logic [DW-1:0]    s_rdata
);
    decode_t dec;

    ba_decode #(.AW(AW)) u_decode (
        .addr  (m_addr),
        .fetch (m_fetch),
        .dec   (dec)
    );

    ba_ctrl #(.AW(AW), .DW(DW), .LANES(LANES)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_addr  (m_addr),
        .m_wdata (m_wdata),
        .dec_in  (dec),
        .m_ready (m_ready),
        .m_rdata (m_rdata),
        .m_err   (m_err),
        .s_req   (s_req),
        .s_we    (s_we),
        .s_addr  (s_addr),
        .s_wdata (s_wdata),
        .s_be    (s_be),
        .s_ready (s_ready),
        .s_rdata (s_rdata)
    );

endmodule

// File: rtl/bitalias_bridge_chk.sv
module bitalias_bridge_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int LANES = DW / 8
) (
    input logic             clk,
    input logic             rst,
    input logic             m_req,
    input logic             m_we,
    input logic [AW-1:0]    m_addr,
    input logic [DW-1:0]    m_wdata,
    input logic             m_ready,
    input logic [DW-1:0]    m_rdata,
    input logic             m_err,
    input logic             s_req,
    input logic             s_we,
    input logic [AW-1:0]    s_addr,
    input logic [DW-1:0]    s_wdata,
    input logic [LANES-1:0] s_be,
    input logic             s_ready
);
    logic             part_rd_q;
    logic [AW-1:0]    part_addr_q;
    logic [LANES-1:0] part_be_q;
    logic             touched_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            part_rd_q   <= 1'b0;
            part_addr_q <= '0;
            part_be_q   <= '0;
            touched_q   <= 1'b0;
        end else begin
            if (s_req && s_ready) begin
                part_rd_q   <= !s_we && (s_be != '1);
                part_addr_q <= s_addr;
                part_be_q   <= s_be;
            end
            if (m_ready)    touched_q <= 1'b0;
            else if (s_req) touched_q <= 1'b1;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> (!m_ready && !s_req));

    // R2
    pass_forward_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_be == '1) |-> (s_addr == m_addr && s_we == m_we && (!s_we || s_wdata == m_wdata)));

    // R3
    single_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_be != '1) |-> ($countones(s_be) == 1 && s_addr[1:0] == 2'b00));

    // R4
    bit_result_chk: assert property (@(posedge clk) disable iff (rst)
        (m_ready && !m_we && part_rd_q) |-> (m_rdata[DW-1:1] == '0));

    // R5
    rmw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && s_we && s_be != '1) |-> (part_rd_q && part_addr_q == s_addr && part_be_q == s_be));

    // R8
    fault_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        (m_ready && m_err) |-> (!touched_q && m_rdata == '0));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        m_ready |=> !m_ready);

    // R9
    slave_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && !s_ready) |=> (s_req && $stable(s_addr) && $stable(s_be) && $stable(s_we)));

    // R9
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (s_req && !m_req) |-> !m_ready);

endmodule

bind bitalias_bridge bitalias_bridge_chk #(.AW(AW), .DW(DW), .LANES(LANES)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .m_err   (m_err),
    .s_req   (s_req),
    .s_we    (s_we),
    .s_addr  (s_addr),
    .s_wdata (s_wdata),
    .s_be    (s_be),
    .s_ready (s_ready)
);

// File: tb/bitalias_bridge_tb_top.sv
module bitalias_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_req = 1'b0;
    logic        m_we = 1'b0;
    logic        m_fetch = 1'b0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_ready;
    logic [31:0] m_rdata;
    logic        m_err;
    logic        s_req;
    logic        s_we;
    logic [31:0] s_addr;
    logic [31:0] s_wdata;
    logic [3:0]  s_be;
    logic        s_ready = 1'b0;
    logic [31:0] s_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [logic [31:0]];
    int          acc_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [3:0]  last_be = '0;
    logic [1:0]  wait_left = '0;

    always #2.5 clk = ~clk;

    bitalias_bridge dut_i (
        .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_fetch(m_fetch),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
        .m_err(m_err), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_be(s_be), .s_ready(s_ready), .s_rdata(s_rdata)
    );

    function automatic logic [31:0] mem_rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    function automatic logic is_alias(input logic [31:0] a);
        return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] a);
        logic [31:0] base;
        logic [31:0] byte_a;
        base   = (a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000;
        byte_a = base + {12'd0, a[24:5]};
        return {byte_a[31:2], 2'b00};
    endfunction

    function automatic logic [4:0] ref_pos(input logic [31:0] a);
        return a[6:2];
    endfunction

    // memory model: random wait, then one-cycle ready; write applied at completion edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            s_ready   <= 1'b0;
            wait_left <= 2'd0;
        end else if (s_ready) begin
            if (s_we) begin
                logic [31:0] w;
                w = mem_rd(s_addr);
                for (int i = 0; i < 4; i++)
                    if (s_be[i]) w[i*8 +: 8] = s_wdata[i*8 +: 8];
                mem[s_addr] = w;
                wr_cnt <= wr_cnt + 1;
            end
            acc_cnt   <= acc_cnt + 1;
            last_addr <= s_addr;
            last_be   <= s_be;
            s_ready   <= 1'b0;
        end else if (s_req) begin
            if (wait_left == 0) begin
                s_ready   <= 1'b1;
                s_rdata   <= mem_rd(s_addr);
                wait_left <= 2'($urandom % 3);
            end else begin
                wait_left <= wait_left - 2'd1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        input logic fetch, output logic [31:0] rd, output logic err);
        @(negedge clk);
        m_addr = a; m_we = we; m_wdata = wd; m_fetch = fetch; m_req = 1'b1;
        do @(negedge clk); while (!m_ready);
        rd = m_rdata; err = m_err;
        m_req = 1'b0; m_we = 1'b0; m_fetch = 1'b0;
        @(negedge clk);
        chk("R9 single ready pulse", {31'd0, m_ready}, 32'd0);
    endtask

    task automatic alias_write(input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] w, exp_w, rd;
        logic err;
        int a0, w0;
        w = ref_word(a);
        exp_w = mem_rd(w);
        exp_w[ref_pos(a)] = wd[0];
        a0 = acc_cnt; w0 = wr_cnt;
        xfer(a, 1'b1, wd, 1'b0, rd, err);
        chk("R5 rmw word", mem_rd(w), exp_w);
        chk("R5 rmw access count", acc_cnt - a0, 2);
        chk("R5 rmw write count", wr_cnt - w0, 1);
        chk("R3 rmw address", last_addr, w);
        chk("R3 rmw byte enable", {28'd0, last_be}, 32'd1 << ref_pos(a)[4:3]);
        chk("R10 no error", {31'd0, err}, 32'd0);
    endtask

    task automatic alias_read(input logic [31:0] a);
        logic [31:0] w, exp_v, rd;
        logic err;
        int a0, w0;
        w = ref_word(a);
        exp_v = {31'd0, mem_rd(w)[ref_pos(a)]};
        a0 = acc_cnt; w0 = wr_cnt;
        xfer(a, 1'b0, 32'd0, 1'b0, rd, err);
        chk("R4 alias read value", rd, exp_v);
        chk("R4 alias read one access", acc_cnt - a0, 1);
        chk("R4 alias read no write", wr_cnt - w0, 0);
        chk("R3 alias read address", last_addr, w);
        chk("R3 alias read byte enable", {28'd0, last_be}, 32'd1 << ref_pos(a)[4:3]);
        chk("R10 no error", {31'd0, err}, 32'd0);
    endtask

    task automatic pass_access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                               input logic fetch);
        logic [31:0] exp_r, rd;
        logic err;
        int a0;
        exp_r = mem_rd(a);
        a0 = acc_cnt;
        xfer(a, we, wd, fetch, rd, err);
        chk("R2 R7 pass one access", acc_cnt - a0, 1);
        chk("R2 R7 pass address", last_addr, a);
        chk("R2 pass byte enable", {28'd0, last_be}, 32'hF);
        if (we) chk("R2 pass write data", mem_rd(a), wd);
        else    chk("R2 R7 pass read data", rd, exp_r);
        chk("R10 no error", {31'd0, err}, 32'd0);
    endtask

    task automatic periph_fetch(input logic [31:0] a);
        logic [31:0] rd;
        logic err;
        int a0;
        a0 = acc_cnt;
        xfer(a, 1'b0, 32'd0, 1'b1, rd, err);
        chk("R8 fetch error flag", {31'd0, err}, 32'd1);
        chk("R8 fetch data zero", rd, 32'd0);
        chk("R8 fetch no access", acc_cnt - a0, 0);
    endtask

    initial begin
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic err;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset m_ready", {31'd0, m_ready}, 32'd0);
        chk("R1 reset s_req", {31'd0, s_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset m_ready", {31'd0, m_ready}, 32'd0);
        chk("R1 after reset s_req", {31'd0, s_req}, 32'd0);

        // R3 corner addresses
        alias_write(32'h23FF_FFFC, 32'h1);
        chk("R3 top alias sets bit 31 of 0x200FFFFC", {31'd0, mem_rd(32'h200F_FFFC)[31]}, 32'd1);
        alias_write(32'h2200_0000, 32'h0);
        chk("R3 base alias clears bit 0 of 0x20000000", {31'd0, mem_rd(32'h2000_0000)[0]}, 32'd0);
        alias_read(32'h2200_0000);
        alias_write(32'h43FF_FFFC, 32'h0);
        alias_read(32'h43FF_FFFC);
        alias_write(32'h4200_0024, 32'h1);
        alias_read(32'h4200_0024);

        // R6 only bit 0 of write data counts
        alias_write(32'h2200_1234 & ~32'd3, 32'hFF);
        xfer(32'h2200_1234 & ~32'd3, 1'b0, 0, 1'b0, rd, err);
        chk("R6 write 0xFF sets", rd, 32'd1);
        alias_write(32'h2200_1234 & ~32'd3, 32'h0E);
        xfer(32'h2200_1234 & ~32'd3, 1'b0, 0, 1'b0, rd, err);
        chk("R6 write 0x0E clears", rd, 32'd0);
        alias_write(32'h2200_1234 & ~32'd3, 32'hFFFF_FFFE);
        xfer(32'h2200_1234 & ~32'd3, 1'b0, 0, 1'b0, rd, err);
        chk("R6 write 0xFFFFFFFE clears", rd, 32'd0);

        // R7 / R8 fetches
        pass_access(32'h2200_0040, 1'b0, 0, 1'b1);
        periph_fetch(32'h4200_0040);
        pass_access(32'h1000_0100, 1'b0, 0, 1'b0);
        pass_access(32'h1000_0100, 1'b1, 32'hDEAD_BEEF, 1'b0);

        // mixed random traffic
        for (int n = 0; n < 400; n++) begin
            int kind;
            logic [31:0] a;
            kind = int'($urandom % 6);
            a = {($urandom % 2) ? 7'h11 : 7'h21, 25'($urandom)} & ~32'd3;
            unique case (kind)
                0: alias_read(a);
                1: alias_write(a, $urandom);
                2: pass_access({7'h11, 25'($urandom)} & ~32'd3, 1'b0, 0, 1'b1);
                3: periph_fetch({7'h21, 25'($urandom)} & ~32'd3);
                4: pass_access(32'h2000_0000 | ($urandom & 32'h000F_FFFC), 1'b0, 0, 1'b0);
                default: pass_access(32'h5000_0000 | ($urandom & 32'h00FF_FFFC), 1'($urandom), $urandom, 1'b0);
            endcase
            if (is_alias(a) && kind == 1) alias_read(a);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule